// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into a slave FPGA that takes serial data. A host pulses `start` and then supplies image bytes one at a time on a ready/valid port, marking the final byte with `in_last`. The sequencer drives the target's active-low program line and its configuration clock and data pins, and it watches the target's init and done status lines. The load has three handshake phases, and each phase has its own programmable cycle limit. If a phase runs past its limit, the load stops and a distinct error code is reported.

Every accepted byte is sent MSB first, one bit per configuration-clock period. When the target signals done, the block runs a two-step user-logic reset on the same pins and then reports success. While the bytes pass through, a small parser follows the length-prefixed text fields in the image header and presents their characters, tagged with the field number, so they can be read out as status.

Top module: `serial_cfg_sequencer`

## Requirements
- R1: After reset, `tgt_prog_n` is 1, `tgt_clk` is 0, and `busy`, `in_ready`, `result_valid` and `result_code` are all 0.
- R2: A `start` pulse while idle drives `tgt_prog_n` low in the next cycle and raises `busy`. The line stays low until `tgt_init` reads low, and it is released in the following cycle.
- R3: If `tgt_init` stays high for `tmo_init_lo`+1 cycles with the program line low, the load ends with result code 1. `busy` is then high for exactly `tmo_init_lo`+1 cycles.
- R4: After the program line is released, if `tgt_init` does not return high within `tmo_init_hi`+1 cycles, the load ends with result code 2 and no byte is accepted.
- R5: Accepted bytes appear on `tgt_din` MSB first. Each bit is captured by the target on a rising edge of `tgt_clk`.
- R6: Each bit period is CLK_HALF cycles with `tgt_clk` low, followed by CLK_HALF cycles with it high. `tgt_din` changes only while the clock is low.
- R7: After the bit of the byte flagged `in_last` has been sent, if `tgt_done` does not rise within `tmo_done`+1 cycles, the load ends with result code 3.
- R8: When `tgt_done` rises, the block holds program high, clock high and data low for RST_HOLD cycles. It then holds all three high for RST_HOLD cycles more, and the load ends with result code 0.
- R9: The end of every load is marked by a single-cycle `result_valid` pulse in the first cycle with `busy` low. `start` has no effect while `busy` is high, and the program line never falls again during that load.
- R10: The header has four fields. The first length byte is at byte offset 15, and each following length byte is at that field's length offset plus its length plus 3. The `length` bytes after each length byte are emitted on `hdr_char`, with the field index (0 to 3) on `hdr_field`, one cycle after they are accepted.
- R11: `in_ready` is high only while streaming, with the serialiser empty and before the last byte has been taken. No byte is accepted at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while busy) |
| tmo_init_lo | input | TMO_W | Cycle limit for init to fall |
| tmo_init_hi | input | TMO_W | Cycle limit for init to rise |
| tmo_done | input | TMO_W | Cycle limit for done to rise |
| in_valid | input | 1 | Image byte valid |
| in_ready | output | 1 | Image byte accepted this cycle when valid |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Byte is the final one of the image |
| tgt_prog_n | output | 1 | Active-low program line to target |
| tgt_clk | output | 1 | Configuration clock to target |
| tgt_din | output | 1 | Configuration data to target |
| tgt_init | input | 1 | Target init status line |
| tgt_done | input | 1 | Target done status line |
| busy | output | 1 | Load in progress |
| result_valid | output | 1 | One-cycle end-of-load strobe |
| result_code | output | 2 | 0 ok, 1 init not low, 2 init not high, 3 done not high |
| hdr_valid | output | 1 | Header text character valid |
| hdr_char | output | 8 | Header text character |
| hdr_field | output | 2 | Index of the header field it belongs to |

## Verification
The assertions assume that the three limit inputs are held constant for the whole of a load. They also assume that the host sends exactly one byte with `in_last` set, and that `tgt_init` and `tgt_done` come from a target that answers the program line. The bench sets its limits once before any start. Its target model answers each handshake phase, or withholds the answer, under per-test switches, and raises done only after the final clock pulse has ended. Its host driver changes inputs only on falling clock edges, and it stops offering bytes as soon as `busy` drops.

// File: rtl/cfg_seq_pkg.sv
`timescale 1ns/1ps
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_LOW,
        ST_INIT_WAIT,
        ST_STREAM,
        ST_DONE_WAIT,
        ST_RST_A,
        ST_RST_B
    } seq_state_e;

    typedef enum logic [1:0] {
        RC_OK      = 2'd0,
        RC_INIT_LO = 2'd1,
        RC_INIT_HI = 2'd2,
        RC_DONE    = 2'd3
    } result_e;

    localparam int FIELD_GAP = 3;

    // position of the next length byte, given this one's position and value
    function automatic logic [15:0] next_field_pos(input logic [15:0] pos,
                                                   input logic [7:0]  len);
        return pos + 16'(len) + 16'(FIELD_GAP);
    endfunction

endpackage

// File: rtl/cfg_seq_timer.sv
`timescale 1ns/1ps
module cfg_seq_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/cfg_seq_shifter.sv
`timescale 1ns/1ps
module cfg_seq_shifter #(
    parameter int CLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] byte_i,
    output logic       busy,
    output logic       sclk,
    output logic       sdata
);
    localparam int HC_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(CLK_HALF - 1);

    logic [7:0]      sh_q;
    logic [3:0]      left_q;
    logic            hi_q;
    logic [HC_W-1:0] hc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
            hi_q   <= 1'b0;
            hc_q   <= '0;
        end else if (load) begin
            sh_q   <= byte_i;
            left_q <= 4'd8;
            hi_q   <= 1'b0;
            hc_q   <= '0;
        end else if (left_q != 4'd0) begin
            if (hc_q == HC_LAST) begin
                hc_q <= '0;
                if (hi_q) begin
                    // falling edge: next bit presented while clock is low
                    hi_q   <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    left_q <= left_q - 4'd1;
                end else begin
                    hi_q <= 1'b1;
                end
            end else begin
                hc_q <= hc_q + 1'b1;
            end
        end
    end

    assign busy  = (left_q != 4'd0);
    assign sclk  = busy & hi_q;
    assign sdata = busy & sh_q[7];
endmodule

// File: rtl/cfg_seq_hdr.sv
`timescale 1ns/1ps
module cfg_seq_hdr
    import cfg_seq_pkg::*;
#(
    parameter int NUM_FIELDS = 4,
    parameter int HDR_START  = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       accept,
    input  logic [7:0] byte_i,
    output logic       txt_valid,
    output logic [7:0] txt_char,
    output logic [$clog2(NUM_FIELDS)-1:0] txt_field
);
    localparam int FW = $clog2(NUM_FIELDS);
    localparam int CW = $clog2(NUM_FIELDS + 1);

    logic [15:0]   idx_q, next_q;
    logic [CW-1:0] seen_q;
    logic [FW-1:0] cur_q;
    logic [7:0]    rem_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q     <= '0;
            next_q    <= 16'(HDR_START);
            seen_q    <= '0;
            cur_q     <= '0;
            rem_q     <= '0;
            txt_valid <= 1'b0;
            txt_char  <= '0;
            txt_field <= '0;
        end else begin
            txt_valid <= 1'b0;
            if (accept) begin
                idx_q <= idx_q + 16'd1;
                if (seen_q < CW'(NUM_FIELDS) && idx_q == next_q) begin
                    cur_q  <= FW'(seen_q);
                    rem_q  <= byte_i;
                    next_q <= next_field_pos(idx_q, byte_i);
                    seen_q <= seen_q + 1'b1;
                end else if (rem_q != 8'd0) begin
                    rem_q     <= rem_q - 8'd1;
                    txt_valid <= 1'b1;
                    txt_char  <= byte_i;
                    txt_field <= cur_q;
                end
            end
        end
    end
endmodule

// File: rtl/serial_cfg_sequencer.sv
`timescale 1ns/1ps
module serial_cfg_sequencer
    import cfg_seq_pkg::*;
#(
    parameter int TMO_W      = 20,
    parameter int CLK_HALF   = 2,
    parameter int RST_HOLD   = 250000,
    parameter int NUM_FIELDS = 4,
    parameter int HDR_START  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TMO_W-1:0] tmo_init_lo,
    input  logic [TMO_W-1:0] tmo_init_hi,
    input  logic [TMO_W-1:0] tmo_done,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             tgt_prog_n,
    output logic             tgt_clk,
    output logic             tgt_din,
    input  logic             tgt_init,
    input  logic             tgt_done,
    output logic             busy,
    output logic             result_valid,
    output logic [1:0]       result_code,
    output logic             hdr_valid,
    output logic [7:0]       hdr_char,
    output logic [$clog2(NUM_FIELDS)-1:0] hdr_field
);
    localparam logic [TMO_W-1:0] RST_LIM = TMO_W'(RST_HOLD - 1);

    seq_state_e       state_q, state_d;
    result_e          code_q, code_d;
    logic             done_d;
    logic             rv_q;
    logic             last_q;
    logic             accept;
    logic             launch;
    logic             tmr_exp;
    logic [TMO_W-1:0] tmr_lim;
    logic             sh_busy, sh_clk, sh_dat;

    assign launch = (state_q == ST_IDLE) && start;
    assign accept = in_valid && in_ready;

    always_comb begin
        unique case (state_q)
            ST_PROG_LOW:  tmr_lim = tmo_init_lo;
            ST_INIT_WAIT: tmr_lim = tmo_init_hi;
            ST_DONE_WAIT: tmr_lim = tmo_done;
            default:      tmr_lim = RST_LIM;
        endcase
    end

    cfg_seq_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_d != state_q),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PROG_LOW;
            ST_PROG_LOW: begin
                if (!tgt_init)    state_d = ST_INIT_WAIT;
                else if (tmr_exp) begin state_d = ST_IDLE; code_d = RC_INIT_LO; done_d = 1'b1; end
            end
            ST_INIT_WAIT: begin
                if (tgt_init)     state_d = ST_STREAM;
                else if (tmr_exp) begin state_d = ST_IDLE; code_d = RC_INIT_HI; done_d = 1'b1; end
            end
            ST_STREAM: if (last_q && !sh_busy) state_d = ST_DONE_WAIT;
            ST_DONE_WAIT: begin
                if (tgt_done)     state_d = ST_RST_A;
                else if (tmr_exp) begin state_d = ST_IDLE; code_d = RC_DONE; done_d = 1'b1; end
            end
            ST_RST_A: if (tmr_exp) state_d = ST_RST_B;
            ST_RST_B: if (tmr_exp) begin state_d = ST_IDLE; code_d = RC_OK; done_d = 1'b1; end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= RC_OK;
            rv_q    <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= launch ? RC_OK : code_d;
            rv_q    <= done_d;
            if (launch)
                last_q <= 1'b0;
            else if (accept && in_last)
                last_q <= 1'b1;
        end
    end

    cfg_seq_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .byte_i (in_data),
        .busy   (sh_busy),
        .sclk   (sh_clk),
        .sdata  (sh_dat)
    );

    cfg_seq_hdr #(.NUM_FIELDS(NUM_FIELDS), .HDR_START(HDR_START)) u_hdr (
        .clk       (clk),
        .rst       (rst),
        .clear     (launch),
        .accept    (accept),
        .byte_i    (in_data),
        .txt_valid (hdr_valid),
        .txt_char  (hdr_char),
        .txt_field (hdr_field)
    );

    assign in_ready     = (state_q == ST_STREAM) && !sh_busy && !last_q;
    assign tgt_prog_n   = (state_q != ST_PROG_LOW);
    assign tgt_clk      = ((state_q == ST_STREAM) && sh_clk) ||
                          (state_q == ST_RST_A) || (state_q == ST_RST_B);
    assign tgt_din      = ((state_q == ST_STREAM) && sh_dat) || (state_q == ST_RST_B);
    assign busy         = (state_q != ST_IDLE);
    assign result_valid = rv_q;
    assign result_code  = code_q;
endmodule

// File: rtl/serial_cfg_sequencer_chk.sv
`timescale 1ns/1ps
module serial_cfg_sequencer_chk
    import cfg_seq_pkg::*;
#(
    parameter int TMO_W = 20
) (
    input logic             clk,
    input logic             rst,
    input seq_state_e       state_q,
    input logic [TMO_W-1:0] tmo_init_lo,
    input logic [TMO_W-1:0] tmo_init_hi,
    input logic [TMO_W-1:0] tmo_done,
    input logic             in_ready,
    input logic             in_valid,
    input logic             tgt_prog_n,
    input logic             tgt_clk,
    input logic             tgt_din,
    input logic             busy,
    input logic             result_valid,
    input logic [1:0]       result_code,
    input logic             hdr_valid
);
    seq_state_e       st_prev;
    logic [TMO_W+1:0] dwell_q, dwell_now;

    assign dwell_now = (state_q != st_prev) ? '0 :
                       (dwell_q == '1) ? dwell_q : dwell_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_prev <= ST_IDLE;
            dwell_q <= '0;
        end else begin
            st_prev <= state_q;
            dwell_q <= dwell_now;
        end
    end

    assert_init_lo_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG_LOW) |-> (dwell_now <= (TMO_W+2)'(tmo_init_lo)));
    assert_init_lo_code_R3: assert property (@(posedge clk) disable iff (rst)
        (result_valid && result_code == 2'd1) |-> ($past(state_q) == ST_PROG_LOW));
    assert_init_hi_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_INIT_WAIT) |-> (dwell_now <= (TMO_W+2)'(tmo_init_hi)));
    assert_done_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE_WAIT) |-> (dwell_now <= (TMO_W+2)'(tmo_done)));
    assert_data_stable_high_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && $past(state_q) == ST_STREAM && tgt_clk && $past(tgt_clk))
        |-> $stable(tgt_din));
    assert_ok_after_reset_seq_R8: assert property (@(posedge clk) disable iff (rst)
        (result_valid && result_code == 2'd0)
        |-> $past(tgt_clk && tgt_din && tgt_prog_n));
    assert_prog_entry_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG_LOW)
        |-> ($past(state_q) == ST_PROG_LOW || $past(state_q) == ST_IDLE));
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);
    assert_ready_streaming_R11: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (busy && tgt_prog_n));
    assert_hdr_follows_accept_R10: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> $past(in_valid && in_ready));
endmodule

bind serial_cfg_sequencer serial_cfg_sequencer_chk #(.TMO_W(TMO_W)) u_chk (.*);

// File: tb/serial_cfg_sequencer_test.sv
`timescale 1ns/1ps
module serial_cfg_sequencer_test;
    localparam int TMO_W = 20;
    localparam int HALF  = 2;
    localparam int HOLD  = 10;
    localparam int LIM_LO = 20, LIM_HI = 30, LIM_DN = 40;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [TMO_W-1:0] tmo_init_lo = TMO_W'(LIM_LO);
    logic [TMO_W-1:0] tmo_init_hi = TMO_W'(LIM_HI);
    logic [TMO_W-1:0] tmo_done    = TMO_W'(LIM_DN);
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, tgt_prog_n, tgt_clk, tgt_din, busy, result_valid, hdr_valid;
    logic [1:0] result_code, hdr_field;
    logic [7:0] hdr_char;
    logic mdl_init = 1'b1, mdl_done = 1'b0;

    serial_cfg_sequencer #(.TMO_W(TMO_W), .CLK_HALF(HALF), .RST_HOLD(HOLD)) uut (
        .clk(clk), .rst(rst), .start(start),
        .tmo_init_lo(tmo_init_lo), .tmo_init_hi(tmo_init_hi), .tmo_done(tmo_done),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .tgt_prog_n(tgt_prog_n), .tgt_clk(tgt_clk), .tgt_din(tgt_din),
        .tgt_init(mdl_init), .tgt_done(mdl_done),
        .busy(busy), .result_valid(result_valid), .result_code(result_code),
        .hdr_valid(hdr_valid), .hdr_char(hdr_char), .hdr_field(hdr_field));

    always #2 clk = ~clk;

    int checks = 0, failures = 0;
    logic [7:0] img [0:63];
    int exp_n = 0;
    bit ack_lo = 1, ack_hi = 1, ack_dn = 1, mdl_clr = 0;

    // target model
    int cap_bits = 0, cap_base = 0;
    logic [7:0] cap_mem [0:1023];
    logic [7:0] cap_sr = '0;
    always @(posedge tgt_clk) begin
        if (!mdl_done) begin
            cap_sr = {cap_sr[6:0], tgt_din};
            if (cap_bits % 8 == 7) cap_mem[(cap_bits / 8) % 1024] = cap_sr;
            cap_bits = cap_bits + 1;
        end
    end
    always @(posedge clk) begin
        if (mdl_clr) begin
            mdl_init <= 1'b1;
            mdl_done <= 1'b0;
        end else begin
            if (!tgt_prog_n && ack_lo) mdl_init <= 1'b0;
            if (tgt_prog_n && !mdl_init && ack_hi) mdl_init <= 1'b1;
            if (ack_dn && busy && !tgt_clk && exp_n > 0 && (cap_bits - cap_base) == 8 * exp_n)
                mdl_done <= 1'b1;
        end
    end

    // observers
    int busy_total = 0, prog_falls = 0, cnt_a = 0, cnt_b = 0, hn = 0;
    int hi_run = 0, hi_min = 1000, hi_max = 0;
    logic [7:0] hq_c [0:1023];
    logic [1:0] hq_f [0:1023];
    always @(negedge tgt_prog_n) prog_falls++;
    always @(negedge clk) begin
        if (busy) busy_total++;
        if (busy && mdl_done && tgt_clk && !tgt_din) cnt_a++;
        if (busy && mdl_done && tgt_clk && tgt_din) cnt_b++;
        if (hdr_valid) begin
            hq_c[hn % 1024] = hdr_char;
            hq_f[hn % 1024] = hdr_field;
            hn++;
        end
        if (mdl_clr) begin
            hi_run = 0; hi_min = 1000; hi_max = 0;
        end else if (busy && !mdl_done && tgt_clk) begin
            hi_run++;
        end else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 150000)", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    int b_busy, b_prog, b_a, b_b, b_hn, b_cap;
    logic rv_seen;
    logic [1:0] rc_seen;
    bit prog_low_seen, ready_seen;

    task automatic run_load(input int n, input bit gaps, input bit poke);
        @(negedge clk);
        mdl_clr = 1;
        @(negedge clk);
        mdl_clr = 0;
        @(negedge clk);
        cap_base = cap_bits; exp_n = n;
        b_busy = busy_total; b_prog = prog_falls; b_a = cnt_a; b_b = cnt_b; b_hn = hn; b_cap = cap_bits;
        ready_seen = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        prog_low_seen = !tgt_prog_n && busy;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    in_valid = 1; in_data = img[i]; in_last = (i == n - 1);
                    while (!in_ready && busy) @(negedge clk);
                    if (!busy) break;
                    ready_seen = 1;
                    @(negedge clk);
                    in_valid = 0; in_last = 0;
                    if (gaps) repeat (5) @(negedge clk);
                end
                in_valid = 0; in_last = 0;
            end
            begin
                if (poke) begin
                    repeat (60) @(negedge clk);
                    start = 1;
                    @(negedge clk);
                    start = 0;
                end
            end
        join
        for (int g = 0; g < 20000 && busy; g++) @(negedge clk);
        rv_seen = result_valid;
        rc_seen = result_code;
        @(negedge clk);
    endtask

    function automatic int bytes_match(input int n);
        for (int i = 0; i < n; i++)
            if (cap_mem[(b_cap / 8 + i) % 1024] !== img[i]) return 0;
        return 1;
    endfunction

    task automatic test_reset_state;
        chk(tgt_prog_n === 1'b1, "R1 prog_n", int'(tgt_prog_n), 1);
        chk(tgt_clk === 1'b0, "R1 clk", int'(tgt_clk), 0);
        chk(busy === 1'b0 && in_ready === 1'b0, "R1 busy/ready", int'(busy) + int'(in_ready), 0);
        chk(result_valid === 1'b0 && result_code === 2'd0, "R1 result", int'(result_code), 0);
    endtask

    task automatic test_good_load;
        for (int i = 0; i < 20; i++) img[i] = 8'(i * 37 + 5);
        ack_lo = 1; ack_hi = 1; ack_dn = 1;
        run_load(20, 0, 0);
        chk(prog_low_seen, "R2 prog low after start", int'(prog_low_seen), 1);
        chk(bytes_match(20) == 1, "R5 msb-first bytes", bytes_match(20), 1);
        chk(hi_min == HALF && hi_max == HALF, "R6 clock high width", hi_max, HALF);
        chk(cnt_a - b_a == HOLD, "R8 reset phase A cycles", cnt_a - b_a, HOLD);
        chk(cnt_b - b_b == HOLD, "R8 reset phase B cycles", cnt_b - b_b, HOLD);
        chk(rv_seen === 1'b1 && rc_seen === 2'd0, "R8 success code", int'(rc_seen), 0);
        chk(result_valid === 1'b0, "R9 strobe one cycle", int'(result_valid), 0);
        chk(in_ready === 1'b0, "R11 ready low when idle", int'(in_ready), 0);
    endtask

    task automatic test_gapped_load;
        for (int i = 0; i < 12; i++) img[i] = (i % 2 == 0) ? 8'hA5 : 8'h3C ^ 8'(i);
        run_load(12, 1, 0);
        chk(bytes_match(12) == 1, "R5 bytes with host stalls", bytes_match(12), 1);
        chk(hi_min == HALF && hi_max == HALF, "R6 clock high width stalled", hi_min, HALF);
        chk(rc_seen === 2'd0, "R8 stalled success", int'(rc_seen), 0);
    endtask

    task automatic test_init_lo_timeout;
        ack_lo = 0; ack_hi = 1; ack_dn = 1;
        for (int i = 0; i < 4; i++) img[i] = 8'hFF;
        run_load(4, 0, 0);
        chk(rv_seen === 1'b1 && rc_seen === 2'd1, "R3 init-not-low code", int'(rc_seen), 1);
        chk(busy_total - b_busy == LIM_LO + 1, "R3 busy cycles", busy_total - b_busy, LIM_LO + 1);
        chk(!ready_seen, "R11 no byte taken on R3 error", int'(ready_seen), 0);
        ack_lo = 1;
    endtask

    task automatic test_init_hi_timeout;
        ack_lo = 1; ack_hi = 0; ack_dn = 1;
        run_load(4, 0, 0);
        chk(rv_seen === 1'b1 && rc_seen === 2'd2, "R4 init-not-high code", int'(rc_seen), 2);
        chk(busy_total - b_busy == 2 + LIM_HI + 1, "R4 busy cycles", busy_total - b_busy, LIM_HI + 3);
        chk(cap_bits == b_cap && !ready_seen, "R4 no data sent", cap_bits - b_cap, 0);
        ack_hi = 1;
    endtask

    task automatic test_done_timeout;
        ack_lo = 1; ack_hi = 1; ack_dn = 0;
        for (int i = 0; i < 6; i++) img[i] = 8'(8'h81 + 8'(i));
        run_load(6, 0, 0);
        chk(rv_seen === 1'b1 && rc_seen === 2'd3, "R7 done-not-high code", int'(rc_seen), 3);
        chk(bytes_match(6) == 1, "R7 data before timeout", bytes_match(6), 1);
        chk(cnt_b == b_b, "R7 no reset sequence", cnt_b - b_b, 0);
        ack_dn = 1;
    endtask

    task automatic test_start_while_busy;
        for (int i = 0; i < 10; i++) img[i] = 8'(8'hF0 - 8'(i * 3));
        run_load(10, 0, 1);
        chk(prog_falls - b_prog == 1, "R9 single program pulse", prog_falls - b_prog, 1);
        chk(bytes_match(10) == 1 && rc_seen === 2'd0, "R9 load unaffected by start", int'(rc_seen), 0);
    endtask

    task automatic test_header;
        int ec [6];
        int ef [6];
        int ok;
        for (int i = 0; i < 40; i++) img[i] = 8'(8'h10 + 8'(i));
        img[15] = 8'd2; img[16] = "A"; img[17] = "B";
        img[20] = 8'd3; img[21] = "X"; img[22] = "Y"; img[23] = "Z";
        img[26] = 8'd0;
        img[29] = 8'd1; img[30] = "Q";
        img[33] = 8'd5;
        ec = '{int'("A"), int'("B"), int'("X"), int'("Y"), int'("Z"), int'("Q")};
        ef = '{0, 0, 1, 1, 1, 3};
        run_load(40, 0, 0);
        chk(hn - b_hn == 6, "R10 header char count", hn - b_hn, 6);
        ok = 1;
        for (int i = 0; i < 6; i++)
            if (int'(hq_c[(b_hn + i) % 1024]) != ec[i] || int'(hq_f[(b_hn + i) % 1024]) != ef[i]) ok = 0;
        chk(ok == 1, "R10 header chars and field tags", ok, 1);
        chk(rc_seen === 2'd0, "R10 header load success", int'(rc_seen), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset_state();
        test_good_load();
        test_gapped_load();
        test_init_lo_timeout();
        test_init_hi_timeout();
        test_done_timeout();
        test_start_while_busy();
        test_header();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule